// File: doc/BRIEF.md
# DMA Event Capture and Prioritizer

This block collects trigger requests for two classes of DMA channel and turns them, one per clock, into pushes into two event queues. A regular channel (64 by default) becomes pending when one of three things happens. An outside event arrives while that channel is enabled. Software writes a one to its bit in the set register. A chain trigger comes in from a finished transfer. A quick-DMA channel (8 by default) becomes pending from its own trigger input. Each class holds one pending bit per channel.

Each cycle the block looks at the pending channels whose mapped queue is not full. A regular channel is always chosen before a quick channel. Within a class, the lowest channel number wins. The chosen channel goes out as a single push that carries the channel index, a class flag and the queue number. Its pending bit is cleared at the same clock edge. A one-bit map for each channel picks its queue. If a trigger arrives for a channel that is already pending, a missed-trigger flag is raised for that channel. Software clears the flag by writing a one to it.

Top module: `dma_evt_prio`

## Requirements
- R1: After reset, every readable register (enable, pending, map and missed flags of both classes) reads zero and push_vld is low.
- R2: An outside event on a regular channel becomes pending only if that channel's enable bit (register address 0, bit = channel) is one. The push for it is visible in the cycle after the event is sampled.
- R3: A write of a one to register address 1 (bit = channel), or a chain trigger, makes a regular channel pending whatever its enable bit holds.
- R4: Among regular channels pending together, the lowest channel number is pushed, with push_qdma = 0 and push_ch = that channel.
- R5: A quick channel is pushed only when no regular channel can be pushed. Among quick channels, the lowest number wins, with push_qdma = 1 and push_ch = that channel.
- R6: push_q equals the channel's map bit. For regular channels the map is register address 3, and for quick channels it is address 4, with bit = channel in both. 0 selects queue 0 and 1 selects queue 1.
- R7: A channel whose mapped queue has its q_full bit set is skipped, and the best channel with room is pushed instead. With both queues full, nothing is pushed.
- R8: A pushed channel's pending bit is cleared at the push edge. A trigger for that same channel in the push cycle leaves it pending and does not raise its missed flag.
- R9: A trigger on a channel that is already pending (and not being pushed) sets its missed flag. The regular flags read at address 5 and the quick flags at address 6. Writing a one to the same address clears the flag.
- R10: Writing a one to address 2 clears a regular pending bit, and writing a one to address 7 clears a quick pending bit. Quick pending bits read at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_evt | input | 64 | Outside events, one per regular channel |
| chain_evt | input | 64 | Chain triggers, one per regular channel |
| qdma_evt | input | 8 | Quick-channel triggers |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | 64 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 64 | Register read data (combinational) |
| q_full | input | 2 | Full flags of queue 1 and queue 0 |
| push_vld | output | 1 | Queue push this cycle |
| push_q | output | 1 | Target queue of the push |
| push_ch | output | 6 | Channel index of the push |
| push_qdma | output | 1 | 1 when the pushed channel is a quick channel |

## Verification
The hardest case to reach is a push edge that happens in the same cycle as a new trigger for the same channel. The pushes normally drain pending bits as soon as they appear. To get there, the stimulus holds both q_full bits high so that pending state builds up. It then lowers them for exactly one cycle while it drives the trigger, and raises them again. Afterwards it reads the pending and missed registers to see whether the channel stayed pending without a missed flag. The same hold-and-release method sets up the full-queue skip and the exact priority order, and it separates each table vector from the next.

// File: rtl/dmaprio_pkg.sv
package dmaprio_pkg;
  localparam int unsigned RADDR_W = 3;
  localparam int unsigned NUM_QUEUES = 2;

  typedef enum logic [RADDR_W-1:0] {
    RA_ENABLE = 3'd0,
    RA_PEND   = 3'd1,
    RA_PCLR   = 3'd2,
    RA_MAP    = 3'd3,
    RA_QMAP   = 3'd4,
    RA_MISS   = 3'd5,
    RA_QMISS  = 3'd6,
    RA_QCLR   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/evt_capture.sv
module evt_capture #(
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] new_evt,
  input  logic [N-1:0] clr_wr,
  input  logic [N-1:0] gnt,
  input  logic [N-1:0] miss_clr,
  output logic [N-1:0] pend,
  output logic [N-1:0] miss
);
  logic [N-1:0] pend_nxt, miss_nxt;
  logic         pend_en, miss_en;

  always_comb begin
    pend_nxt = (pend & ~clr_wr & ~gnt) | new_evt;
    miss_nxt = (miss & ~miss_clr) | (new_evt & pend & ~gnt);
    pend_en  = |(new_evt | clr_wr | gnt);
    miss_en  = |(miss_clr | (new_evt & pend));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      miss <= '0;
    end else begin
      if (pend_en) pend <= pend_nxt;
      if (miss_en) miss <= miss_nxt;
    end
  end

  p_one_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_grant_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |=> ((pend & $past(gnt & ~new_evt)) == '0));

  p_relatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & new_evt) != '0) |=> ((pend & $past(gnt & new_evt)) == $past(gnt & new_evt)));

  p_miss_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((new_evt & pend & ~gnt) != '0) |=> (miss != '0));
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int unsigned N  = 64,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    found  = |req;
    onehot = found ? (N'(1) << idx) : '0;
  end

  p_pick_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> req[idx]);

  p_pick_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ((req & ((N'(1) << idx) - N'(1))) == '0));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import dmaprio_pkg::*;
#(
  parameter int unsigned N_DMA  = 64,
  parameter int unsigned N_QDMA = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [N_DMA-1:0]   reg_wdata,
  output logic [N_DMA-1:0]   en,
  output logic [N_DMA-1:0]   map,
  output logic [N_QDMA-1:0]  qmap
);
  logic en_we, map_we, qmap_we;

  always_comb begin
    en_we   = reg_wr && (reg_addr == RA_ENABLE);
    map_we  = reg_wr && (reg_addr == RA_MAP);
    qmap_we = reg_wr && (reg_addr == RA_QMAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      map  <= '0;
      qmap <= '0;
    end else begin
      if (en_we)   en   <= reg_wdata;
      if (map_we)  map  <= reg_wdata;
      if (qmap_we) qmap <= reg_wdata[N_QDMA-1:0];
    end
  end
endmodule

// File: rtl/dma_evt_prio.sv
module dma_evt_prio
  import dmaprio_pkg::*;
#(
  parameter int unsigned N_DMA  = 64,
  parameter int unsigned N_QDMA = 8,
  localparam int unsigned CH_W  = $clog2(N_DMA),
  localparam int unsigned QI_W  = (N_QDMA > 1) ? $clog2(N_QDMA) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_DMA-1:0]      ext_evt,
  input  logic [N_DMA-1:0]      chain_evt,
  input  logic [N_QDMA-1:0]     qdma_evt,
  input  logic                  reg_wr,
  input  logic [RADDR_W-1:0]    reg_addr,
  input  logic [N_DMA-1:0]      reg_wdata,
  input  logic [RADDR_W-1:0]    rd_addr,
  output logic [N_DMA-1:0]      rd_data,
  input  logic [NUM_QUEUES-1:0] q_full,
  output logic                  push_vld,
  output logic                  push_q,
  output logic [CH_W-1:0]       push_ch,
  output logic                  push_qdma
);
  logic [N_DMA-1:0]  en, map, d_pend, d_miss, d_new, d_clr, d_mclr, d_blk, d_req, d_hot, d_gnt;
  logic [N_QDMA-1:0] qmap, q_pend, q_miss, q_clr, q_mclr, q_blk, q_req, q_hot, q_gnt;
  logic [CH_W-1:0]   d_idx;
  logic [QI_W-1:0]   q_idx;
  logic              d_found, q_found;
  logic [N_DMA-1:0]  wr_ones;

  cfg_regs #(.N_DMA(N_DMA), .N_QDMA(N_QDMA)) u_cfg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .en(en), .map(map), .qmap(qmap)
  );

  always_comb begin
    wr_ones = reg_wr ? reg_wdata : '0;
    d_new   = (ext_evt & en) | chain_evt | ((reg_addr == RA_PEND) ? wr_ones : '0);
    d_clr   = (reg_addr == RA_PCLR)  ? wr_ones : '0;
    d_mclr  = (reg_addr == RA_MISS)  ? wr_ones : '0;
    q_clr   = (reg_addr == RA_QCLR)  ? wr_ones[N_QDMA-1:0] : '0;
    q_mclr  = (reg_addr == RA_QMISS) ? wr_ones[N_QDMA-1:0] : '0;
  end

  // per-channel view of whether the mapped queue can take a push
  for (genvar i = 0; i < N_DMA; i++) begin : g_dblk
    assign d_blk[i] = q_full[map[i]];
  end
  for (genvar j = 0; j < N_QDMA; j++) begin : g_qblk
    assign q_blk[j] = q_full[qmap[j]];
  end

  assign d_req = d_pend & ~d_blk;
  assign q_req = q_pend & ~q_blk;

  prio_pick #(.N(N_DMA), .IW(CH_W)) u_dpick (
    .clk(clk), .rst_n(rst_n), .req(d_req), .found(d_found), .idx(d_idx), .onehot(d_hot)
  );
  prio_pick #(.N(N_QDMA), .IW(QI_W)) u_qpick (
    .clk(clk), .rst_n(rst_n), .req(q_req), .found(q_found), .idx(q_idx), .onehot(q_hot)
  );

  always_comb begin
    d_gnt     = d_hot;
    q_gnt     = d_found ? '0 : q_hot;
    push_vld  = d_found | q_found;
    push_qdma = !d_found && q_found;
    push_ch   = d_found ? d_idx : CH_W'(q_idx);
    push_q    = d_found ? map[d_idx] : qmap[q_idx];
  end

  evt_capture #(.N(N_DMA)) u_dcap (
    .clk(clk), .rst_n(rst_n), .new_evt(d_new), .clr_wr(d_clr), .gnt(d_gnt),
    .miss_clr(d_mclr), .pend(d_pend), .miss(d_miss)
  );
  evt_capture #(.N(N_QDMA)) u_qcap (
    .clk(clk), .rst_n(rst_n), .new_evt(qdma_evt), .clr_wr(q_clr), .gnt(q_gnt),
    .miss_clr(q_mclr), .pend(q_pend), .miss(q_miss)
  );

  always_comb begin
    unique case (rd_addr)
      RA_ENABLE: rd_data = en;
      RA_PEND:   rd_data = d_pend;
      RA_PCLR:   rd_data = N_DMA'(q_pend);
      RA_MAP:    rd_data = map;
      RA_QMAP:   rd_data = N_DMA'(qmap);
      RA_MISS:   rd_data = d_miss;
      RA_QMISS:  rd_data = N_DMA'(q_miss);
      default:   rd_data = '0;
    endcase
  end

  p_push_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_vld |-> !q_full[push_q]);

  p_dma_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && push_qdma) |-> (d_gnt == '0));

  p_push_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && !push_qdma) |-> d_pend[push_ch]);
endmodule

// File: tb/sim_dma_evt_prio.sv
module sim_dma_evt_prio;
  import dmaprio_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] ext_evt, chain_evt, reg_wdata, rd_data;
  logic [7:0]  qdma_evt;
  logic        reg_wr;
  logic [2:0]  reg_addr, rd_addr;
  logic [1:0]  q_full;
  logic        push_vld, push_q, push_qdma;
  logic [5:0]  push_ch;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dma_evt_prio u0 (
    .clk(clk), .rst_n(rst_n), .ext_evt(ext_evt), .chain_evt(chain_evt),
    .qdma_evt(qdma_evt), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .q_full(q_full), .push_vld(push_vld),
    .push_q(push_q), .push_ch(push_ch), .push_qdma(push_qdma)
  );

  typedef struct packed {
    logic [63:0] ext;
    logic [63:0] chn;
    logic [7:0]  qev;
    logic [5:0]  ch;
    logic        isq;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{64'h8000_0000_0000_0000, 64'h0, 8'h00, 6'd63, 1'b0},
    '{64'h0000_0100_0000_0400, 64'h0, 8'h00, 6'd10, 1'b0},
    '{64'h0000_0000_0000_0080, 64'h20, 8'h00, 6'd5, 1'b0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'hFF, 6'd0, 1'b0},
    '{64'h0, 64'h0, 8'h84, 6'd2, 1'b1},
    '{64'h0, 64'h0, 8'h80, 6'd7, 1'b1},
    '{64'h0000_0002_0000_0000, 64'h0, 8'h01, 6'd33, 1'b0},
    '{64'h0, 64'h4000_0000_0000_0000, 8'hFF, 6'd62, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [63:0] exp);
    rd_addr = a;
    #2;
    chk(req, rd_data, exp);
  endtask

  task automatic pulse(input logic [63:0] e, input logic [63:0] c, input logic [7:0] q);
    @(negedge clk);
    ext_evt = e; chain_evt = c; qdma_evt = q;
    @(negedge clk);
    ext_evt = '0; chain_evt = '0; qdma_evt = '0;
  endtask

  // open both queues, look at the push, close them before the next edge
  task automatic peek(input string req, input logic [1:0] fl, input logic v,
                      input logic [5:0] ch, input logic isq, input logic qsel);
    q_full = fl;
    #2;
    chk(req, {63'd0, push_vld}, {63'd0, v});
    if (v) begin
      chk(req, {58'd0, push_ch}, {58'd0, ch});
      chk(req, {63'd0, push_qdma}, {63'd0, isq});
      chk(req, {63'd0, push_q}, {63'd0, qsel});
    end
    q_full = 2'b11;
  endtask

  task automatic drain();
    q_full = 2'b11;
    wr(RA_PCLR, '1);
    wr(RA_QCLR, '1);
    wr(RA_MISS, '1);
    wr(RA_QMISS, '1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; ext_evt = '0; chain_evt = '0; qdma_evt = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; rd_addr = '0; q_full = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 7; a++) rd("R1 regs zero", 3'(a), 64'd0);
    q_full = 2'b00; #2;
    chk("R1 no push", {63'd0, push_vld}, 64'd0);
    q_full = 2'b11;

    // R2 enable gating
    pulse(64'h20, '0, '0);
    rd("R2 disabled event dropped", RA_PEND, 64'd0);
    wr(RA_ENABLE, 64'h20);
    pulse(64'h60, '0, '0);
    rd("R2 only enabled latched", RA_PEND, 64'h20);
    peek("R2 push", 2'b00, 1'b1, 6'd5, 1'b0, 1'b0);
    drain();

    // R3 manual set and chain ignore enable
    wr(RA_PEND, 64'h10_0000);
    pulse('0, 64'h20_0000, '0);
    rd("R3 set and chain pend", RA_PEND, 64'h30_0000);
    drain();

    // R4/R5 table of simultaneous patterns
    wr(RA_ENABLE, '1);
    for (int k = 0; k < 8; k++) begin
      pulse(VECS[k].ext, VECS[k].chn, VECS[k].qev);
      peek(VECS[k].isq ? "R5 class/quick order" : "R4 lowest regular", 2'b00, 1'b1,
           VECS[k].ch, VECS[k].isq, 1'b0);
      drain();
    end

    // R6 queue mapping
    wr(RA_MAP, 64'h200);
    wr(RA_PEND, 64'h200);
    peek("R6 regular map", 2'b00, 1'b1, 6'd9, 1'b0, 1'b1);
    drain();
    wr(RA_QMAP, 64'h4);
    pulse('0, '0, 8'h04);
    peek("R6 quick map", 2'b00, 1'b1, 6'd2, 1'b1, 1'b1);
    drain();

    // R7 full-queue skip
    wr(RA_MAP, 64'h8);
    wr(RA_PEND, 64'h88);
    peek("R7 skip to queue0", 2'b10, 1'b1, 6'd7, 1'b0, 1'b0);
    peek("R7 skip to queue1", 2'b01, 1'b1, 6'd3, 1'b0, 1'b1);
    peek("R7 both full", 2'b11, 1'b0, 6'd0, 1'b0, 1'b0);
    drain();

    // R8 clear on push, same-cycle re-latch
    wr(RA_PEND, 64'h10);
    @(negedge clk);
    q_full = 2'b00; ext_evt = 64'h10;
    @(negedge clk);
    q_full = 2'b11; ext_evt = '0;
    rd("R8 relatched", RA_PEND, 64'h10);
    rd("R8 no miss on relatch", RA_MISS, 64'd0);
    @(negedge clk);
    q_full = 2'b00;
    @(negedge clk);
    q_full = 2'b11;
    rd("R8 cleared by push", RA_PEND, 64'd0);
    drain();

    // R9 missed flags
    wr(RA_PEND, 64'h40);
    wr(RA_PEND, 64'h40);
    rd("R9 regular miss", RA_MISS, 64'h40);
    wr(RA_MISS, 64'h40);
    rd("R9 regular miss cleared", RA_MISS, 64'd0);
    pulse('0, '0, 8'h02);
    pulse('0, '0, 8'h02);
    rd("R9 quick miss", RA_QMISS, 64'h02);
    wr(RA_QMISS, 64'h02);
    rd("R9 quick miss cleared", RA_QMISS, 64'd0);
    drain();

    // R10 clear writes
    wr(RA_PEND, 64'h1000);
    wr(RA_PCLR, 64'h1000);
    rd("R10 regular clear", RA_PEND, 64'd0);
    pulse('0, '0, 8'h08);
    rd("R10 quick pending", RA_PCLR, 64'h08);
    wr(RA_QCLR, 64'h08);
    rd("R10 quick clear", RA_PCLR, 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule